// File: doc/BRIEF.md
# Power mode and clock controller

This block sits between the oscillator-driven processor clock and the rest of the chip. It produces three kinds of clock from one source. The first is a gated processor clock. The second is a peripheral clock that runs at the source rate divided by 1, 2 or 4. The third is one gated copy of the peripheral clock for each peripheral. It also drives the oscillator-enable output. Software programs it through a small four-register port: a mode register, a divider register, a peripheral enable mask and an external wake enable mask. Every gate uses a latch that only opens while the source clock is low, so a gated clock never shows a shortened pulse.

The behaviour is built around a four-state machine:
- `ST_RUN`: all clocks run.
- `ST_IDLE`: the processor clock is stopped and the peripheral clocks run.
- `ST_PDOWN`: every clock is stopped and the oscillator enable is low.
- `ST_SETTLE`: the oscillator has been restarted, but every gated clock is still held off.

The state machine has five named transitions:
- T_SLEEP (`ST_RUN` to `ST_IDLE`): taken on a mode write of 01.
- T_DEEP (`ST_RUN` to `ST_PDOWN`): taken on a mode write of 10.
- T_IRQ (`ST_IDLE` to `ST_RUN`): taken when the interrupt request is high.
- T_OSC_BACK (`ST_PDOWN` to `ST_SETTLE`): taken when the synchronised wake latch is seen.
- T_SETTLED (`ST_SETTLE` to `ST_RUN`): taken after the settle count has run out.

Reset forces `ST_RUN` from any state.

Leaving power-down does not depend on any clock. An enabled external wake input sets an asynchronous latch, and that latch raises the oscillator enable at once. Only after the clock comes back is the latch synchronised into the state machine. The latch is cleared in `ST_SETTLE`.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the registers and outputs take these values:
  - the mode field reads 00 and the divider field reads 01;
  - the peripheral enable mask reads all ones and the wake enable mask reads zero;
  - `osc_en` is high and `per_clk` pulses on every processor clock cycle.
- R2: The register addresses are 0 for mode, 1 for the divider, 2 for the peripheral mask and 3 for the wake mask. The divider field is `reg_wdata[1:0]` at address 1. Its codes are 00 for divide by 4, 01 for divide by 1, 10 for divide by 2, and 11 for divide by 1. `per_clk` gives one high pulse every N source cycles, and writing the divider restarts the count.
- R3: Bit i of the mask at address 2 enables `periph_clk[i]`. When the bit is clear, that clock shows no pulse.
- R4: Writing mode 01 (bits [1:0] at address 0) in run mode selects idle mode. The cycle that captures the write still carries a full `cpu_clk` pulse. From the next cycle `cpu_clk` stops, `per_clk` keeps pulsing and the mode field reads 01.
- R5: In idle mode, a high `irq_req` at a clock edge returns the block to run mode. `cpu_clk` pulses from the following cycle and the mode field reads 00.
- R6: Writing mode 10 in run mode selects power-down. `osc_en` falls, and `cpu_clk`, `per_clk` and every `periph_clk` bit stay low.
- R7: In power-down, `irq_req` and external wake inputs whose bit in the wake mask (address 3) is clear leave `osc_en` low.
- R8: In power-down, an external wake input whose mask bit is set raises `osc_en` with no clock edge needed.
- R9: After a power-down wake, all gated clocks stay off for SETTLE_CYC cycles. The first `cpu_clk` pulse falls on rising edge SETTLE_CYC+4 of the restarted clock. Afterwards the mode field reads 00, and the divider and mask settings are unchanged.
- R10: Reset asserted during power-down raises `osc_en` and restores the R1 register values while the clock is stopped.
- R11: A mode write of 11 is ignored and the block stays in run mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source processor clock from the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_req | input | 1 | Any enabled interrupt request (idle exit) |
| ext_wake | input | NUM_WAKE | Asynchronous external wake inputs |
| cpu_clk | output | 1 | Gated processor clock |
| per_clk | output | 1 | Divided peripheral clock |
| periph_clk | output | NUM_PERIPH | Per-peripheral gated clocks |
| osc_en | output | 1 | Oscillator enable |

## Verification
The hardest situation to reach is a power-down wake. The only thing that can move the block at that point is an asynchronous input. To build it, the bench models the oscillator: it stops toggling `clk_in` whenever `osc_en` is low. The bench then pulses a masked wake input and raises `irq_req`, confirms that `osc_en` stays low, and only then pulses an enabled wake input between grid ticks. It counts restarted clock edges until the first processor pulse, and checks that no peripheral pulse appears during the settle window.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PDOWN  = 2'd2,
        ST_SETTLE = 2'd3
    } pm_state_e;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_IDLE  = 2'b01;
    localparam logic [1:0] MODE_PDOWN = 2'b10;

    localparam logic [1:0] DIV_BY4 = 2'b00;
    localparam logic [1:0] DIV_BY1 = 2'b01;
    localparam logic [1:0] DIV_BY2 = 2'b10;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_PEN  = 2'd2;
    localparam logic [1:0] ADDR_WEN  = 2'd3;

    // Division ratio selected by the divider field; reserved code runs 1:1.
    function automatic int ratio_of(logic [1:0] code);
        int r;
        unique case (code)
            DIV_BY4: r = 4;
            DIV_BY2: r = 2;
            default: r = 1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcc_clk_gate.sv
module pcc_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);

    logic en_l;

    // Enable can only change while the clock is low: no runt pulses.
    always_latch begin
        if (!clk_i) en_l <= en_i;
    end

    assign gclk_o = clk_i & en_l;

endmodule

// File: rtl/pcc_divider.sv
module pcc_divider
    import pcc_pkg::*;
#(
    parameter int MAX_RATIO = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] code_i,
    input  logic       restart_i,
    output logic       tick_o
);

    localparam int CW = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;

    logic [CW-1:0] cnt_q;
    int            ratio;

    assign ratio  = ratio_of(code_i);
    assign tick_o = (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i || (int'(cnt_q) >= ratio - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    p_div_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(cnt_q) < ratio);

endmodule

// File: rtl/pcc_wake.sv
module pcc_wake #(
    parameter int NUM_WAKE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                armed_i,
    input  logic                clr_i,
    input  logic [NUM_WAKE-1:0] ext_wake_i,
    input  logic [NUM_WAKE-1:0] wake_en_i,
    output logic                wake_q_o,
    output logic                wake_sync_o
);

    logic                   wake_set;
    logic                   wake_q;
    logic [SYNC_STAGES-1:0] sync_q;

    assign wake_set = armed_i & (|(ext_wake_i & wake_en_i));

    // Clockless capture: the set side needs no edge of clk_i.
    always_ff @(posedge clk_i or negedge rst_ni or posedge wake_set) begin
        if (!rst_ni) begin
            wake_q <= 1'b0;
        end else if (wake_set) begin
            wake_q <= 1'b1;
        end else if (clr_i) begin
            wake_q <= 1'b0;
        end
    end

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q <= '0;
                else         sync_q <= wake_q;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sync_q <= '0;
                else         sync_q <= {sync_q[SYNC_STAGES-2:0], wake_q};
            end
        end
    endgenerate

    assign wake_q_o    = wake_q;
    assign wake_sync_o = sync_q[SYNC_STAGES-1];

    p_wake_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_q && !clr_i) |=> wake_q);

endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
    import pcc_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      req_idle_i,
    input  logic      req_pdown_i,
    input  logic      irq_i,
    input  logic      wake_i,
    output pm_state_e state_o,
    output logic      cpu_run_o,
    output logic      per_run_o,
    output logic      wake_clr_o
);

    localparam int            CW   = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    pm_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          settle_done;

    assign settle_done = (cnt_q == LAST);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (req_pdown_i)     st_d = ST_PDOWN;   // T_DEEP
                else if (req_idle_i) st_d = ST_IDLE;    // T_SLEEP
            end
            ST_IDLE:   if (irq_i)       st_d = ST_RUN;     // T_IRQ
            ST_PDOWN:  if (wake_i)      st_d = ST_SETTLE;  // T_OSC_BACK
            ST_SETTLE: if (settle_done) st_d = ST_RUN;     // T_SETTLED
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ST_SETTLE) ? cnt_q + CW'(1) : '0;
        end
    end

    always_comb begin
        cpu_run_o  = 1'b0;
        per_run_o  = 1'b0;
        wake_clr_o = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                cpu_run_o = 1'b1;
                per_run_o = 1'b1;
            end
            ST_IDLE:   per_run_o  = 1'b1;
            ST_PDOWN:  ;
            ST_SETTLE: wake_clr_o = 1'b1;
        endcase
    end

    assign state_o = st_q;

    p_idle_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RUN && req_idle_i && !req_pdown_i) |=> st_q == ST_IDLE);

    p_idle_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_IDLE && irq_i) |=> st_q == ST_RUN);

    p_pdown_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RUN && req_pdown_i) |=> st_q == ST_PDOWN);

    p_settle_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_q) == ST_SETTLE && st_q == ST_RUN) |-> $past(cnt_q) == LAST);

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pcc_pkg::*;
#(
    parameter int NUM_PERIPH  = 8,
    parameter int NUM_WAKE    = 4,
    parameter int DATA_W      = 8,
    parameter int SETTLE_CYC  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk_in,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  irq_req,
    input  logic [NUM_WAKE-1:0]   ext_wake,
    output logic                  cpu_clk,
    output logic                  per_clk,
    output logic [NUM_PERIPH-1:0] periph_clk,
    output logic                  osc_en
);

    pm_state_e             state;
    logic                  cpu_run, per_run, wake_clr;
    logic                  wake_q, wake_sync;
    logic                  per_tick;
    logic [1:0]            div_q;
    logic [NUM_PERIPH-1:0] pen_q;
    logic [NUM_WAKE-1:0]   wen_q;
    logic [1:0]            mode_rb;
    logic                  mode_wr, div_wr, req_idle, req_pdown;

    assign mode_wr   = reg_wr && (reg_addr == ADDR_MODE);
    assign div_wr    = reg_wr && (reg_addr == ADDR_DIV);
    assign req_idle  = mode_wr && (reg_wdata[1:0] == MODE_IDLE);
    assign req_pdown = mode_wr && (reg_wdata[1:0] == MODE_PDOWN);

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_BY1;
            pen_q <= '1;
            wen_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                ADDR_DIV:  div_q <= reg_wdata[1:0];
                ADDR_PEN:  pen_q <= reg_wdata[NUM_PERIPH-1:0];
                ADDR_WEN:  wen_q <= reg_wdata[NUM_WAKE-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN:  mode_rb = MODE_RUN;
            ST_IDLE: mode_rb = MODE_IDLE;
            default: mode_rb = MODE_PDOWN;
        endcase
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_MODE: reg_rdata = DATA_W'(mode_rb);
            ADDR_DIV:  reg_rdata = DATA_W'(div_q);
            ADDR_PEN:  reg_rdata = DATA_W'(pen_q);
            ADDR_WEN:  reg_rdata = DATA_W'(wen_q);
        endcase
    end

    pcc_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk_i       (clk_in),
        .rst_ni      (rst_n),
        .req_idle_i  (req_idle),
        .req_pdown_i (req_pdown),
        .irq_i       (irq_req),
        .wake_i      (wake_sync),
        .state_o     (state),
        .cpu_run_o   (cpu_run),
        .per_run_o   (per_run),
        .wake_clr_o  (wake_clr)
    );

    pcc_wake #(.NUM_WAKE(NUM_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk_i       (clk_in),
        .rst_ni      (rst_n),
        .armed_i     (state == ST_PDOWN),
        .clr_i       (wake_clr),
        .ext_wake_i  (ext_wake),
        .wake_en_i   (wen_q),
        .wake_q_o    (wake_q),
        .wake_sync_o (wake_sync)
    );

    pcc_divider #(.MAX_RATIO(4)) u_div (
        .clk_i     (clk_in),
        .rst_ni    (rst_n),
        .code_i    (div_q),
        .restart_i (div_wr),
        .tick_o    (per_tick)
    );

    assign osc_en = (state != ST_PDOWN) || wake_q;

    pcc_clk_gate u_cpu_gate (
        .clk_i  (clk_in),
        .en_i   (cpu_run),
        .gclk_o (cpu_clk)
    );

    pcc_clk_gate u_per_gate (
        .clk_i  (clk_in),
        .en_i   (per_tick & per_run),
        .gclk_o (per_clk)
    );

    generate
        for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_pgate
            pcc_clk_gate u_gate (
                .clk_i  (clk_in),
                .en_i   (per_tick & per_run & pen_q[g]),
                .gclk_o (periph_clk[g])
            );
        end
    endgenerate

    p_mode_rsv_r11: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state == ST_RUN && mode_wr && reg_wdata[1:0] == 2'b11) |=> state == ST_RUN);

endmodule

// File: tb/pwr_clk_ctrl_test.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_test;

    localparam int NP     = 8;
    localparam int NW     = 4;
    localparam int SETTLE = 16;

    logic          clk_in = 1'b0;
    logic          rst_n  = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = 8'd0;
    logic [7:0]    reg_rdata;
    logic          irq_req = 1'b0;
    logic [NW-1:0] ext_wake = '0;
    logic          cpu_clk, per_clk, osc_en;
    logic [NP-1:0] periph_clk;

    int checks = 0;
    int errors = 0;
    int cpu_cnt, per_cnt;
    logic [NP-1:0] seen;
    logic [7:0] rd;
    bit done = 0;

    pwr_clk_ctrl #(.NUM_PERIPH(NP), .NUM_WAKE(NW), .DATA_W(8), .SETTLE_CYC(SETTLE)) uut (
        .clk_in(clk_in), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .ext_wake(ext_wake), .cpu_clk(cpu_clk), .per_clk(per_clk),
        .periph_clk(periph_clk), .osc_en(osc_en)
    );

    // Oscillator model: 125 MHz, halts low while osc_en is low.
    always begin
        #4;
        if (osc_en || clk_in) clk_in = ~clk_in;
    end

    typedef struct packed {
        logic [1:0] div;
        logic [7:0] mask;
        logic [4:0] npulse;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'b00, 8'hFF, 5'd4},
        '{2'b10, 8'h0F, 5'd8},
        '{2'b01, 8'hA5, 5'd16},
        '{2'b11, 8'h3C, 5'd16},
        '{2'b00, 8'h00, 5'd4},
        '{2'b10, 8'h81, 5'd8}
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(posedge clk_in); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk_in); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a);
        reg_addr = a; #1;
        rd = reg_rdata;
    endtask

    task automatic sample(int n);
        cpu_cnt = 0; per_cnt = 0; seen = '0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk_in); #1;
            cpu_cnt += int'(cpu_clk);
            per_cnt += int'(per_clk);
            seen |= periph_clk;
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int settle_per;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk_in);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0); chk("R1 mode", rd, 0);
        rd_reg(2'd1); chk("R1 div", rd, 1);
        rd_reg(2'd2); chk("R1 pen", rd, 8'hFF);
        rd_reg(2'd3); chk("R1 wen", rd, 0);
        chk("R1 osc_en", int'(osc_en), 1);
        sample(16);
        chk("R1 per_clk 1:1", per_cnt, 16);
        chk("R1 cpu_clk", cpu_cnt, 16);

        // R2/R3 vector table
        foreach (VEC[i]) begin
            wr(2'd1, {6'd0, VEC[i].div});
            wr(2'd2, VEC[i].mask);
            rd_reg(2'd1); chk("R2 div readback", rd, int'(VEC[i].div));
            sample(16);
            chk("R2 per_clk pulses", per_cnt, int'(VEC[i].npulse));
            chk("R3 periph mask", int'(seen), int'(VEC[i].mask));
        end

        // R11 reserved mode
        wr(2'd0, 8'h03);
        rd_reg(2'd0); chk("R11 mode after 11", rd, 0);
        sample(8); chk("R11 cpu runs", cpu_cnt, 8);

        // R4 idle entry (divide by 2)
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h01);
        chk("R4 last cpu pulse full", int'(cpu_clk), 1);
        rd_reg(2'd0); chk("R4 mode idle", rd, 1);
        sample(16);
        chk("R4 cpu stopped", cpu_cnt, 0);
        chk("R4 per runs", per_cnt, 8);

        // R5 idle exit
        @(posedge clk_in); #2 irq_req = 1'b1;
        @(posedge clk_in); #2 irq_req = 1'b0;
        rd_reg(2'd0); chk("R5 mode run", rd, 0);
        sample(4); chk("R5 cpu resumes", cpu_cnt, 4);

        // R6 power-down entry (divide by 4, wake bit 1 enabled)
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h02);
        wr(2'd0, 8'h02);
        #100;
        chk("R6 osc_en low", int'(osc_en), 0);
        chk("R6 clock halted", int'(clk_in), 0);
        chk("R6 cpu low", int'(cpu_clk), 0);
        chk("R6 per low", int'(per_clk), 0);
        chk("R6 periph low", int'(periph_clk), 0);

        // R7 no wake from irq or masked input
        irq_req = 1'b1; #48;
        chk("R7 irq ignored", int'(osc_en), 0);
        irq_req = 1'b0;
        ext_wake[0] = 1'b1; #20;
        chk("R7 masked wake ignored", int'(osc_en), 0);
        ext_wake[0] = 1'b0; #20;

        // R8 enabled wake, no clock
        ext_wake[1] = 1'b1; #1;
        chk("R8 osc_en async", int'(osc_en), 1);
        ext_wake[1] = 1'b0;

        // R9 settle window
        n = 0; settle_per = 0;
        do begin
            @(posedge clk_in); #1;
            n++;
            if (!cpu_clk) settle_per += int'(per_clk) + int'(|periph_clk);
        end while (!cpu_clk && n < 100);
        chk("R9 first cpu edge", n, SETTLE + 4);
        chk("R9 no per pulse in settle", settle_per, 0);
        rd_reg(2'd0); chk("R9 mode run", rd, 0);
        rd_reg(2'd1); chk("R9 div kept", rd, 0);
        sample(16);
        chk("R9 cpu after settle", cpu_cnt, 16);
        chk("R9 per after settle", per_cnt, 4);

        // R10 reset while powered down
        wr(2'd0, 8'h02);
        #100;
        chk("R10 osc off before reset", int'(osc_en), 0);
        rst_n = 1'b0; #1;
        chk("R10 osc_en on", int'(osc_en), 1);
        rd_reg(2'd0); chk("R10 mode", rd, 0);
        rd_reg(2'd1); chk("R10 div", rd, 1);
        rd_reg(2'd2); chk("R10 pen", rd, 8'hFF);
        rd_reg(2'd3); chk("R10 wen", rd, 0);
        @(posedge clk_in); #2 rst_n = 1'b1;
        sample(16);
        chk("R10 per 1:1", per_cnt, 16);
        chk("R10 cpu runs", cpu_cnt, 16);

        done = 1;
        summary();
        $finish;
    end

endmodule